// File: doc/BRIEF.md
# Three-Phase Dead-Time Gate Logic

This block sits between a motor-control pulse generator and the gate-drive stages of a three-phase inverter. For each phase it receives two active-low commands, one for the upper switch and one for the lower switch. It returns two active-high gate enables per phase. It guarantees that the enables of a phase are never asserted together, and that a programmable dead interval separates one switch releasing from its partner engaging.

Every command first passes through a synchronizer and a glitch filter. A decoder then treats a phase with both commands active as a request for neither switch. A per-phase controller adds the dead interval and stretches short on-pulses to a minimum width. Two inputs from the fault supervisor override the controllers. One is a chip-wide shutdown. The other is a per-phase lockout that blocks only that phase's upper switch. The three phases use identical, independent logic, so they have the same command-to-gate latency.

Filter length, dead time, minimum on-width and synchronizer depth are parameters counted in clock cycles.

Top module: `tri_phase_gate_guard`

## Requirements
- R1: A command input held low turns on the matching gate enable. From an idle phase, the enable rises on the SYNC_STAGES+FILT_CYC+DT_CYC+2nd clock edge after the input falls.
- R2: Within a phase, the upper and lower enables are never high in the same cycle.
- R3: A command level change that lasts fewer than FILT_CYC cycles never reaches the enables.
- R4: After a phase's enable falls, both enables of that phase stay low for at least DT_CYC+1 cycles before either rises. When a phase's commands swap sides directly, the old enable falls SYNC_STAGES+FILT_CYC+1 edges after the swap, and the new enable rises DT_CYC+1 edges after that.
- R5: The dead-time count restarts whenever the filtered request of a phase changes. A filtered request lasting fewer than DT_CYC+2 cycles produces no pulse.
- R6: Once an enable rises, it stays high for at least MINW_CYC cycles unless shutdown or lockout intervenes. For an input pulse of L cycles with L at least DT_CYC+2, the output pulse width is the larger of MINW_CYC and L-DT_CYC-1.
- R7: While both commands of a phase are low, neither enable of that phase turns on. Once one command is released, the other side turns on with the R1 latency.
- R8: A high shutdown clears all enables on the next clock edge and restarts every dead-time count. With the commands still held, each enable returns DT_CYC+1 edges after the last edge that saw shutdown high.
- R9: A high lockout bit forces the upper enable of its phase low on the next edge and keeps it from turning on. It has no effect on that phase's lower enable or on any other phase. After release, the upper enable returns on the first edge once the dead time is satisfied.
- R10: The phases act independently with identical latency. Simultaneous commands on several phases produce enables that rise in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hi_cmd_n | input | NPH | Active-low upper-switch commands, one per phase |
| lo_cmd_n | input | NPH | Active-low lower-switch commands, one per phase |
| shutdown | input | 1 | Chip-wide forced off, active high |
| hs_lock | input | NPH | Per-phase upper-switch lockout, active high |
| hs_en | output | NPH | Upper gate enables, active high |
| ls_en | output | NPH | Lower gate enables, active high |

## Verification
Each wrong internal state shows up at the enables within a bounded number of cycles. A filter counter that qualifies too early lets a pulse shorter than the filter length produce an output pulse. A dead-time counter that fails to restart turns a short filtered request into a pulse of exactly the minimum width. A width counter that saturates early or late changes the measured pulse width by exactly the size of the error. The bench therefore sweeps input pulse length on every phase and side, and compares both the onset cycle and the pulse width with closed-form expectations. The first wrong cycle appears within about twenty edges of the stimulus.

// File: rtl/gg_pkg.sv
package gg_pkg;
  typedef enum logic [1:0] {
    SIDE_OFF = 2'd0,
    SIDE_HI  = 2'd1,
    SIDE_LO  = 2'd2
  } side_e;
endpackage

// File: rtl/gg_input_filter.sv
module gg_input_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic req
);
  localparam int RW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b1;
          else        sync_q[gi] <= raw_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b1;
          else        sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  logic          sync_out;
  logic          flt_q, flt_d, flt_en;
  logic [RW-1:0] run_q, run_d;

  assign sync_out = sync_q[SYNC_STAGES-1];

  always_comb begin
    flt_d  = flt_q;
    flt_en = 1'b0;
    run_d  = run_q;
    if (sync_out == flt_q) begin
      run_d = '0;
    end else if (run_q == RW'(FILT_CYC - 1)) begin
      flt_d  = sync_out;
      flt_en = 1'b1;
      run_d  = '0;
    end else begin
      run_d = run_q + RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= 1'b1;
      run_q <= '0;
    end else begin
      if (flt_en) flt_q <= flt_d;
      run_q <= run_d;
    end
  end

  assign req = ~flt_q;

  AST_FILT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flt_q) |-> ($past(run_q) == RW'(FILT_CYC - 1))); // R3
endmodule

// File: rtl/gg_phase_ctrl.sv
module gg_phase_ctrl
  import gg_pkg::*;
#(
  parameter int DT_CYC   = 4,
  parameter int MINW_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_hi,
  input  logic req_lo,
  input  logic shutdown,
  input  logic hs_lock,
  output logic hs_en,
  output logic ls_en
);
  localparam int DW = $clog2(DT_CYC + 1);
  localparam int WW = $clog2(MINW_CYC + 1);

  side_e         want;
  side_e         side_q, side_d;
  side_e         pend_q, pend_d;
  logic [DW-1:0] dt_q, dt_d;
  logic [WW-1:0] wid_q, wid_d;
  logic          dt_done, wid_done, go_off;

  always_comb begin
    if (req_hi && !req_lo)      want = SIDE_HI;
    else if (req_lo && !req_hi) want = SIDE_LO;
    else                        want = SIDE_OFF;
  end

  assign dt_done  = (dt_q == DW'(DT_CYC));
  assign wid_done = (wid_q >= WW'(MINW_CYC));

  always_comb begin
    go_off = 1'b0;
    case (side_q)
      SIDE_HI: go_off = hs_lock || ((want != SIDE_HI) && wid_done);
      SIDE_LO: go_off = (want != SIDE_LO) && wid_done;
      default: go_off = 1'b0;
    endcase
  end

  always_comb begin
    side_d = side_q;
    pend_d = pend_q;
    dt_d   = dt_q;
    wid_d  = wid_q;
    if (shutdown) begin
      side_d = SIDE_OFF;
      pend_d = want;
      dt_d   = '0;
    end else if (side_q == SIDE_OFF) begin
      if (want != pend_q) begin
        pend_d = want;
        dt_d   = '0;
      end else if (!dt_done) begin
        dt_d = dt_q + DW'(1);
      end else if (want == SIDE_HI && !hs_lock) begin
        side_d = SIDE_HI;
        wid_d  = WW'(1);
      end else if (want == SIDE_LO) begin
        side_d = SIDE_LO;
        wid_d  = WW'(1);
      end
    end else if (go_off) begin
      side_d = SIDE_OFF;
      pend_d = want;
      dt_d   = '0;
    end else if (!wid_done) begin
      wid_d = wid_q + WW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      side_q <= SIDE_OFF;
      pend_q <= SIDE_OFF;
      dt_q   <= '0;
      wid_q  <= '0;
    end else begin
      side_q <= side_d;
      pend_q <= pend_d;
      dt_q   <= dt_d;
      wid_q  <= wid_d;
    end
  end

  assign hs_en = (side_q == SIDE_HI);
  assign ls_en = (side_q == SIDE_LO);

  logic          on_q;
  logic [DW-1:0] off_run_q;
  assign on_q = hs_en || ls_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          off_run_q <= '0;
    else if (on_q)                       off_run_q <= '0;
    else if (off_run_q != DW'(DT_CYC))   off_run_q <= off_run_q + DW'(1);
  end

  AST_DEAD_GAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> ($past(off_run_q) == DW'(DT_CYC))); // R4
  AST_DEAD_GAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> ($past(off_run_q) == DW'(DT_CYC))); // R4
  AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |=> !ls_en); // R2
  AST_BOTH_REQ_NO_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hi && req_lo && !on_q) |=> !on_q); // R7
  AST_SHDN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> !on_q); // R8
  AST_LOCK_HS: assert property (@(posedge clk) disable iff (!rst_n)
    hs_lock |=> !hs_en); // R9
  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(on_q) && !$past(shutdown) && !$past(hs_lock && hs_en))
      |-> ($past(wid_q) >= WW'(MINW_CYC))); // R6
endmodule

// File: rtl/tri_phase_gate_guard.sv
module tri_phase_gate_guard #(
  parameter int NPH         = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 3,
  parameter int DT_CYC      = 4,
  parameter int MINW_CYC    = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] hi_cmd_n,
  input  logic [NPH-1:0] lo_cmd_n,
  input  logic           shutdown,
  input  logic [NPH-1:0] hs_lock,
  output logic [NPH-1:0] hs_en,
  output logic [NPH-1:0] ls_en
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [NPH-1:0] req_hi, req_lo;

  genvar gp;
  generate
    for (gp = 0; gp < NPH; gp++) begin : g_phase
      gg_input_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) u_flt_hi (
        .clk(clk), .rst_n(rst_core_n), .raw_n(hi_cmd_n[gp]), .req(req_hi[gp]));
      gg_input_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) u_flt_lo (
        .clk(clk), .rst_n(rst_core_n), .raw_n(lo_cmd_n[gp]), .req(req_lo[gp]));
      gg_phase_ctrl #(.DT_CYC(DT_CYC), .MINW_CYC(MINW_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_core_n),
        .req_hi(req_hi[gp]), .req_lo(req_lo[gp]),
        .shutdown(shutdown), .hs_lock(hs_lock[gp]),
        .hs_en(hs_en[gp]), .ls_en(ls_en[gp]));
    end
  endgenerate

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_core_n)
    (hs_en & ls_en) == '0); // R2
endmodule

// File: tb/tb_tri_phase_gate_guard.sv
`timescale 1ns/1ps
module tb_tri_phase_gate_guard;
  localparam int NPH = 3, SYNC = 2, FILT = 3, DT = 4, MINW = 6;
  localparam int LAT = SYNC + FILT + DT + 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n;
  logic [NPH-1:0] hi_n, lo_n, lock, hs_en, ls_en;
  logic           shdn;

  tri_phase_gate_guard #(.NPH(NPH), .SYNC_STAGES(SYNC), .FILT_CYC(FILT),
    .DT_CYC(DT), .MINW_CYC(MINW)) dut (
    .clk(clk), .rst_n(rst_n), .hi_cmd_n(hi_n), .lo_cmd_n(lo_n),
    .shutdown(shdn), .hs_lock(lock), .hs_en(hs_en), .ls_en(ls_en));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic idle();
    hi_n = '1; lo_n = '1; lock = '0; shdn = 1'b0;
    cyc(40);
  endtask

  task automatic pulse_run(input int p, input bit side_hi, input int len);
    int first, width, overlap, exp_w;
    string tag;
    idle();
    first = -1; width = 0; overlap = 0;
    if (side_hi) hi_n[p] = 1'b0; else lo_n[p] = 1'b0;
    for (int k = 1; k <= 90; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == len) begin hi_n[p] = 1'b1; lo_n[p] = 1'b1; end
      if (side_hi ? hs_en[p] : ls_en[p]) begin
        width++;
        if (first < 0) first = k;
      end
      if (hs_en[p] && ls_en[p]) overlap++;
    end
    exp_w = (len >= DT + 2) ? ((MINW > len - DT - 1) ? MINW : len - DT - 1) : 0;
    if (len < FILT)         tag = "R3";
    else if (len < DT + 2)  tag = "R5";
    else                    tag = "R6";
    chk(width == exp_w, tag, width, exp_w);
    if (exp_w > 0) chk(first == LAT, "R1", first, LAT);
    chk(overlap == 0, "R2", overlap, 0);
  endtask

  initial begin
    int last_hs, first_ls, on_cnt, first;
    int f[NPH];
    rst_n = 1'b0; hi_n = '1; lo_n = '1; lock = '0; shdn = 1'b0;
    cyc(5);
    chk(hs_en == '0 && ls_en == '0, "R1", {hs_en, ls_en}, 0);
    rst_n = 1'b1;
    cyc(10);

    // R1 R3 R5 R6 R2: sweep pulse length over every phase and side
    for (int p = 0; p < NPH; p++)
      for (int s = 0; s < 2; s++)
        for (int len = 1; len <= 16; len++)
          pulse_run(p, s[0], len);

    // R4: direct swap from upper to lower
    idle();
    hi_n[1] = 1'b0; cyc(30);
    hi_n[1] = 1'b1; lo_n[1] = 1'b0;
    last_hs = 0; first_ls = -1;
    for (int k = 1; k <= 30; k++) begin
      @(posedge clk); @(negedge clk);
      if (hs_en[1]) last_hs = k;
      if (ls_en[1] && first_ls < 0) first_ls = k;
    end
    chk(last_hs == SYNC + FILT, "R4", last_hs, SYNC + FILT);
    chk(first_ls == SYNC + FILT + DT + 2, "R4", first_ls, SYNC + FILT + DT + 2);

    // R7: both commands active
    idle();
    hi_n[2] = 1'b0; lo_n[2] = 1'b0;
    on_cnt = 0;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk); @(negedge clk);
      if (hs_en[2] || ls_en[2]) on_cnt++;
    end
    chk(on_cnt == 0, "R7", on_cnt, 0);
    lo_n[2] = 1'b1; first = -1;
    for (int k = 1; k <= 30; k++) begin
      @(posedge clk); @(negedge clk);
      if (hs_en[2] && first < 0) first = k;
    end
    chk(first == LAT, "R7", first, LAT);

    // R8: shutdown
    idle();
    hi_n = '0; cyc(30);
    chk(hs_en == '1, "R8", hs_en, 7);
    shdn = 1'b1; cyc(1);
    chk(hs_en == '0 && ls_en == '0, "R8", {hs_en, ls_en}, 0);
    shdn = 1'b0; first = -1;
    for (int k = 1; k <= 20; k++) begin
      @(posedge clk); @(negedge clk);
      if (hs_en == '1 && first < 0) first = k;
    end
    chk(first == DT + 1, "R8", first, DT + 1);

    // R9: lockout on one phase
    idle();
    hi_n[0] = 1'b0; hi_n[1] = 1'b0; lo_n[2] = 1'b0; cyc(30);
    lock[0] = 1'b1; lock[2] = 1'b1; cyc(1);
    chk(hs_en[0] == 1'b0, "R9", hs_en[0], 0);
    chk(hs_en[1] == 1'b1 && ls_en[2] == 1'b1, "R9", {hs_en[1], ls_en[2]}, 3);
    cyc(8);
    chk(hs_en[0] == 1'b0, "R9", hs_en[0], 0);
    lock = '0; cyc(1);
    chk(hs_en[0] == 1'b1, "R9", hs_en[0], 1);

    // R10: simultaneous commands on all phases, mixed sides
    idle();
    hi_n[0] = 1'b0; lo_n[1] = 1'b0; hi_n[2] = 1'b0;
    for (int p = 0; p < NPH; p++) f[p] = -1;
    for (int k = 1; k <= 30; k++) begin
      @(posedge clk); @(negedge clk);
      if (hs_en[0] && f[0] < 0) f[0] = k;
      if (ls_en[1] && f[1] < 0) f[1] = k;
      if (hs_en[2] && f[2] < 0) f[2] = k;
    end
    for (int p = 0; p < NPH; p++) chk(f[p] == LAT, "R10", f[p], LAT);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule